// File: doc/BRIEF.md
# Tagged Word FIFO Repacker

This block sits between a 32-bit word port and a serial shifter that consumes and produces 16-bit tagged entries. Each entry holds a tag byte in bits 15:8 and a data byte in bits 7:0. On the transmit side, every 32-bit word written by software is split into two entries and queued: the lower half goes first, then the upper half. On the receive side, bytes coming back from the shifter are packed two to a 32-bit word and queued for software to read.

Both queues report not-empty, and the transmit queue reports full. A transfer counter on each side can be loaded with an entry count. When the count runs out, the block raises a done flag and a service flag. In block mode the service flag also rises at every block boundary. In FIFO mode it rises only at the end of the count. Service flags and the transmit overflow flag are cleared by writing ones. Queue sizes come from block-size and FIFO-size codes. Block codes 0, 1 and 2 give 4, 16 and 32 entries. The raw slot count is the block size times 2 to the power (code+1). Because the receive queue stores two bytes per word, it holds half as many words as it has raw slots.

Top module: `tfr_repacker`

## Requirements
- R1: After synchronous reset, both queues are empty, out_full, out_svc, in_svc, out_done, in_done and out_ovf are low, and rx_ready is high.
- R2: A word written with wr_en becomes two entries on ent_data. Bits 15:0 (tag in 15:8, data in 7:0) are presented first, then bits 31:16, each one removed by ent_ready while ent_valid is high.
- R3: A written word whose bits 31:16 are all zero queues only one entry, from bits 15:0.
- R4: The transmit queue holds OUT_DEPTH entries (8 by default). out_full is high when fewer than two slots are free. A write needing more slots than are free is dropped whole, and out_ovf is set and stays set.
- R5: Receive bytes accepted on rx_valid and rx_ready are packed two per word. The first byte goes to bits 7:0, the second to bits 23:16, and all other bits are zero. The word appears on rd_word while in_not_empty is high and is removed by rd_en.
- R6: When the receive count reaches its last byte and no earlier byte is waiting for a partner, that byte is queued alone in bits 7:0 with all upper bits zero.
- R7: out_cnt_load loads the transmit count. Each consumed entry decrements it while it is nonzero. When it reaches zero, out_done and out_svc rise; further entries change neither.
- R8: With out_blk_mode high, out_svc also rises after every OUT_BLK consumed entries (4 by default). With it low, block boundaries raise nothing.
- R9: The receive count behaves the same way with in_cnt_load, accepted bytes, in_done, in_svc and in_blk_mode (block of IN_BLK bytes).
- R10: flag_clr bit 0 clears out_svc, bit 1 clears in_svc and bit 2 clears out_ovf. A set in the same cycle wins over the clear.
- R11: rx_ready is low while the receive queue is full, and a byte offered then is not taken. rd_en on an empty receive queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| out_blk_mode | input | 1 | Transmit service per block (1) or per count (0) |
| in_blk_mode | input | 1 | Receive service per block (1) or per count (0) |
| out_cnt_load | input | 1 | Load the transmit entry count |
| out_cnt_val | input | CNT_W | Transmit entry count value |
| in_cnt_load | input | 1 | Load the receive byte count |
| in_cnt_val | input | CNT_W | Receive byte count value |
| flag_clr | input | 3 | Write-one-to-clear: out_svc, in_svc, out_ovf |
| wr_en | input | 1 | Write a word to the transmit queue |
| wr_word | input | 32 | Word holding two tagged entries |
| rd_en | input | 1 | Remove the head receive word |
| rd_word | output | 32 | Head receive word |
| ent_valid | output | 1 | Transmit entry available |
| ent_data | output | 16 | Head transmit entry |
| ent_ready | input | 1 | Shifter consumes the head entry |
| rx_valid | input | 1 | Shifter offers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Receive byte can be taken |
| out_not_empty | output | 1 | Transmit queue holds entries |
| in_not_empty | output | 1 | Receive queue holds words |
| out_full | output | 1 | Fewer than two transmit slots free |
| out_svc | output | 1 | Transmit service flag |
| in_svc | output | 1 | Receive service flag |
| out_done | output | 1 | Transmit count finished |
| in_done | output | 1 | Receive count finished |
| out_ovf | output | 1 | Transmit write dropped |

## Verification
Some properties hold on every cycle, and the assertions check those. A two-entry write seen while out_full is high must set out_ovf. A service or done flag may only rise right after a consumed entry or an accepted byte. A write-one clear with no concurrent set must lower the flag. A stalled rx_ready implies a non-empty receive queue.

Other behaviour only shows up over a sequence of steps, so the directed scenarios cover it. These include the order of the two halves, the single-entry case and the packing positions of received bytes. They also include the flushing of a final odd byte, and the dropped write together with the content that survives it. Finally, they show the difference between block-boundary and end-of-count service.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

    localparam int WORD_W = 32;
    localparam int ENT_W  = 16;
    localparam int BYTE_W = 8;

    // flag_clr bit positions
    localparam int CLR_OUT_SVC = 0;
    localparam int CLR_IN_SVC  = 1;
    localparam int CLR_OVF     = 2;

    typedef struct packed {
        logic [BYTE_W-1:0] tag;
        logic [BYTE_W-1:0] data;
    } tfr_entry_t;

    typedef struct packed {
        tfr_entry_t hi;
        tfr_entry_t lo;
    } tfr_word_t;

    // block size in entries for a size code
    function automatic int blk_entries(input int code);
        case (code)
            0:       return 4;
            1:       return 16;
            default: return 32;
        endcase
    endfunction

    // raw slot count for a block code and fifo code
    function automatic int fifo_slots(input int blk_code, input int fifo_code);
        return blk_entries(blk_code) * (2 << fifo_code);
    endfunction

endpackage

// File: rtl/tfr_fifo.sv
module tfr_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_a,
    input  logic [W-1:0] din_a,
    input  logic         push_b,
    input  logic [W-1:0] din_b,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic [AW:0]  count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          pop_ok;

    assign pop_ok = pop && (count != '0);
    assign dout   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_a) mem[wr_ptr] <= din_a;
        if (push_a && push_b) mem[wr_ptr + AW'(1)] <= din_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_a) + AW'(push_a && push_b);
            rd_ptr <= rd_ptr + AW'(pop_ok);
            count  <= count + (AW+1)'(push_a) + (AW+1)'(push_a && push_b)
                            - (AW+1)'(pop_ok);
        end
    end
endmodule

// File: rtl/tfr_xfer_counter.sv
module tfr_xfer_counter #(
    parameter int CNT_W = 9,
    parameter int BLK   = 4,
    localparam int BW   = $clog2(BLK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             blk_mode,
    input  logic             step,
    output logic             last,
    output logic             done,
    output logic             svc_pulse
);
    logic [CNT_W-1:0] remaining;
    logic [BW-1:0]    blk_cnt;
    logic             live;
    logic             blk_edge;

    assign last      = (remaining == CNT_W'(1));
    assign live      = step && (remaining != '0);
    assign blk_edge  = blk_mode && (blk_cnt == BW'(BLK - 1));
    assign svc_pulse = live && (last || blk_edge);

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
            blk_cnt   <= '0;
            done      <= 1'b0;
        end else if (load) begin
            remaining <= load_val;
            blk_cnt   <= '0;
            done      <= 1'b0;
        end else if (live) begin
            remaining <= remaining - CNT_W'(1);
            blk_cnt   <= blk_cnt + BW'(1);
            if (last) done <= 1'b1;
        end
    end
endmodule

// File: rtl/tfr_out_path.sv
module tfr_out_path
    import tfr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              ent_ready,
    output logic              ent_valid,
    output logic [ENT_W-1:0]  ent_data,
    output logic              out_full,
    output logic              drop,
    output logic              step
);
    tfr_word_t   word;
    logic [AW:0] count;
    logic [AW:0] free;
    logic        two;
    logic        fits;
    logic        accept;

    assign word   = tfr_word_t'(wr_word);
    assign two    = (word.hi != '0);
    assign free   = (AW+1)'(DEPTH) - count;
    assign fits   = two ? (free >= (AW+1)'(2)) : (free >= (AW+1)'(1));
    assign accept = wr_en && fits;
    assign drop   = wr_en && !fits;

    assign ent_valid = (count != '0);
    assign out_full  = (free < (AW+1)'(2));
    assign step      = ent_valid && ent_ready;

    tfr_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .push_a (accept),
        .din_a  (word.lo),
        .push_b (accept && two),
        .din_b  (word.hi),
        .pop    (step),
        .dout   (ent_data),
        .count  (count)
    );
endmodule

// File: rtl/tfr_in_path.sv
module tfr_in_path
    import tfr_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              last_byte,
    input  logic              rd_en,
    output logic              rx_ready,
    output logic              take,
    output logic [WORD_W-1:0] rd_word,
    output logic              in_not_empty
);
    logic [AW:0]       count;
    logic              staged;
    logic [BYTE_W-1:0] stage_byte;
    logic              push;
    tfr_word_t         packed_word;

    assign rx_ready     = (count != (AW+1)'(WORDS));
    assign take         = rx_valid && rx_ready;
    assign push         = take && (staged || last_byte);
    assign in_not_empty = (count != '0);

    always_comb begin
        packed_word = '0;
        if (staged) begin
            packed_word.lo.data = stage_byte;
            packed_word.hi.data = rx_byte;
        end else begin
            packed_word.lo.data = rx_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged     <= 1'b0;
            stage_byte <= '0;
        end else if (take) begin
            if (staged || last_byte) begin
                staged <= 1'b0;
            end else begin
                staged     <= 1'b1;
                stage_byte <= rx_byte;
            end
        end
    end

    tfr_fifo #(.W(WORD_W), .DEPTH(WORDS)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .push_a (push),
        .din_a  (packed_word),
        .push_b (1'b0),
        .din_b  ('0),
        .pop    (rd_en),
        .dout   (rd_word),
        .count  (count)
    );
endmodule

// File: rtl/tfr_repacker.sv
module tfr_repacker
    import tfr_pkg::*;
#(
    parameter int OUT_BLK_CODE  = 0,
    parameter int OUT_FIFO_CODE = 0,
    parameter int IN_BLK_CODE   = 0,
    parameter int IN_FIFO_CODE  = 0,
    parameter int CNT_W         = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             out_blk_mode,
    input  logic             in_blk_mode,
    input  logic             out_cnt_load,
    input  logic [CNT_W-1:0] out_cnt_val,
    input  logic             in_cnt_load,
    input  logic [CNT_W-1:0] in_cnt_val,
    input  logic [2:0]       flag_clr,
    input  logic             wr_en,
    input  logic [31:0]      wr_word,
    input  logic             rd_en,
    output logic [31:0]      rd_word,
    output logic             ent_valid,
    output logic [15:0]      ent_data,
    input  logic             ent_ready,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             rx_ready,
    output logic             out_not_empty,
    output logic             in_not_empty,
    output logic             out_full,
    output logic             out_svc,
    output logic             in_svc,
    output logic             out_done,
    output logic             in_done,
    output logic             out_ovf
);
    localparam int OUT_BLK   = blk_entries(OUT_BLK_CODE);
    localparam int OUT_DEPTH = fifo_slots(OUT_BLK_CODE, OUT_FIFO_CODE);
    localparam int IN_BLK    = blk_entries(IN_BLK_CODE);
    localparam int IN_WORDS  = fifo_slots(IN_BLK_CODE, IN_FIFO_CODE) / 2;

    logic out_step;
    logic out_drop;
    logic out_pulse;
    logic out_last;
    logic in_take;
    logic in_pulse;
    logic in_last;

    tfr_out_path #(.DEPTH(OUT_DEPTH)) u_out (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .ent_ready (ent_ready),
        .ent_valid (ent_valid),
        .ent_data  (ent_data),
        .out_full  (out_full),
        .drop      (out_drop),
        .step      (out_step)
    );

    tfr_in_path #(.WORDS(IN_WORDS)) u_in (
        .clk          (clk),
        .rst          (rst),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .last_byte    (in_last),
        .rd_en        (rd_en),
        .rx_ready     (rx_ready),
        .take         (in_take),
        .rd_word      (rd_word),
        .in_not_empty (in_not_empty)
    );

    tfr_xfer_counter #(.CNT_W(CNT_W), .BLK(OUT_BLK)) u_out_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (out_cnt_load),
        .load_val  (out_cnt_val),
        .blk_mode  (out_blk_mode),
        .step      (out_step),
        .last      (out_last),
        .done      (out_done),
        .svc_pulse (out_pulse)
    );

    tfr_xfer_counter #(.CNT_W(CNT_W), .BLK(IN_BLK)) u_in_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (in_cnt_load),
        .load_val  (in_cnt_val),
        .blk_mode  (in_blk_mode),
        .step      (in_take),
        .last      (in_last),
        .done      (in_done),
        .svc_pulse (in_pulse)
    );

    assign out_not_empty = ent_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_svc <= 1'b0;
            in_svc  <= 1'b0;
            out_ovf <= 1'b0;
        end else begin
            if (out_pulse)                     out_svc <= 1'b1;
            else if (flag_clr[CLR_OUT_SVC])    out_svc <= 1'b0;
            if (in_pulse)                      in_svc  <= 1'b1;
            else if (flag_clr[CLR_IN_SVC])     in_svc  <= 1'b0;
            if (out_drop)                      out_ovf <= 1'b1;
            else if (flag_clr[CLR_OVF])        out_ovf <= 1'b0;
        end
    end

    logic unused_last;
    assign unused_last = out_last;
endmodule

// File: rtl/tfr_repacker_chk.sv
module tfr_repacker_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  flag_clr,
    input logic        wr_en,
    input logic [31:0] wr_word,
    input logic        ent_valid,
    input logic        ent_ready,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic        out_not_empty,
    input logic        in_not_empty,
    input logic        out_full,
    input logic        out_svc,
    input logic        in_svc,
    input logic        out_done,
    input logic        out_ovf
);
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (out_full && wr_en && wr_word[31:16] != 16'h0) |=> out_ovf); // R4

    AST_SVC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (out_svc && flag_clr[0] && !(ent_valid && ent_ready)) |=> !out_svc); // R10

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(out_done) |-> $past(ent_valid && ent_ready)); // R7

    AST_IN_SVC_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(in_svc) |-> $past(rx_valid && rx_ready)); // R9

    AST_RX_STALL: assert property (@(posedge clk) disable iff (rst)
        !rx_ready |-> in_not_empty); // R11

    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!out_not_empty && !wr_en) |=> !out_not_empty); // R2
endmodule

bind tfr_repacker tfr_repacker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .flag_clr      (flag_clr),
    .wr_en         (wr_en),
    .wr_word       (wr_word),
    .ent_valid     (ent_valid),
    .ent_ready     (ent_ready),
    .rx_valid      (rx_valid),
    .rx_ready      (rx_ready),
    .out_not_empty (out_not_empty),
    .in_not_empty  (in_not_empty),
    .out_full      (out_full),
    .out_svc       (out_svc),
    .in_svc        (in_svc),
    .out_done      (out_done),
    .out_ovf       (out_ovf)
);

// File: tb/tfr_repacker_bench.sv
module tfr_repacker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 9;

    logic             clk = 1'b0;
    logic             rst;
    logic             out_blk_mode, in_blk_mode;
    logic             out_cnt_load, in_cnt_load;
    logic [CNT_W-1:0] out_cnt_val, in_cnt_val;
    logic [2:0]       flag_clr;
    logic             wr_en;
    logic [31:0]      wr_word;
    logic             rd_en;
    logic [31:0]      rd_word;
    logic             ent_valid;
    logic [15:0]      ent_data;
    logic             ent_ready;
    logic             rx_valid;
    logic [7:0]       rx_byte;
    logic             rx_ready;
    logic             out_not_empty, in_not_empty, out_full;
    logic             out_svc, in_svc, out_done, in_done, out_ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tfr_repacker u_tfr_repacker (
        .clk(clk), .rst(rst),
        .out_blk_mode(out_blk_mode), .in_blk_mode(in_blk_mode),
        .out_cnt_load(out_cnt_load), .out_cnt_val(out_cnt_val),
        .in_cnt_load(in_cnt_load), .in_cnt_val(in_cnt_val),
        .flag_clr(flag_clr), .wr_en(wr_en), .wr_word(wr_word),
        .rd_en(rd_en), .rd_word(rd_word),
        .ent_valid(ent_valid), .ent_data(ent_data), .ent_ready(ent_ready),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .out_not_empty(out_not_empty), .in_not_empty(in_not_empty),
        .out_full(out_full), .out_svc(out_svc), .in_svc(in_svc),
        .out_done(out_done), .in_done(in_done), .out_ovf(out_ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] w);
        wr_en = 1'b1; wr_word = w;
        tick();
        wr_en = 1'b0; wr_word = '0;
    endtask

    task automatic pop_entry(input string req, input logic [15:0] exp);
        chk(req, 32'(ent_valid), 32'd1);
        chk(req, 32'(ent_data), 32'(exp));
        ent_ready = 1'b1;
        tick();
        ent_ready = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic read_word(input string req, input logic [31:0] exp);
        chk(req, 32'(in_not_empty), 32'd1);
        chk(req, rd_word, exp);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic clear_flags(input logic [2:0] m);
        flag_clr = m;
        tick();
        flag_clr = '0;
    endtask

    task automatic load_out(input int n, input logic blk);
        out_blk_mode = blk; out_cnt_load = 1'b1; out_cnt_val = CNT_W'(n);
        tick();
        out_cnt_load = 1'b0;
    endtask

    task automatic load_in(input int n, input logic blk);
        in_blk_mode = blk; in_cnt_load = 1'b1; in_cnt_val = CNT_W'(n);
        tick();
        in_cnt_load = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 out_not_empty", 32'(out_not_empty), 0);
        chk("R1 in_not_empty", 32'(in_not_empty), 0);
        chk("R1 flags", 32'({out_full, out_svc, in_svc, out_done, in_done, out_ovf}), 0);
        chk("R1 rx_ready", 32'(rx_ready), 1);
    endtask

    task automatic t_split();
        write_word(32'h0255_01AA);
        pop_entry("R2 low half first", 16'h01AA);
        pop_entry("R2 high half second", 16'h0255);
        chk("R2 drained", 32'(out_not_empty), 0);
    endtask

    task automatic t_odd();
        write_word(32'h0000_03C3);
        pop_entry("R3 single entry", 16'h03C3);
        chk("R3 no second entry", 32'(out_not_empty), 0);
    endtask

    task automatic t_full();
        write_word(32'h0102_0101);
        write_word(32'h0104_0103);
        write_word(32'h0106_0105);
        chk("R4 six held not full", 32'(out_full), 0);
        write_word(32'h0000_0107);
        chk("R4 seven held full", 32'(out_full), 1);
        write_word(32'h0000_0108);
        chk("R4 single fits last slot", 32'(out_ovf), 0);
        write_word(32'h0000_0109);
        chk("R4 overflow set", 32'(out_ovf), 1);
        for (int i = 1; i <= 8; i++) pop_entry("R4 content", 16'(16'h0100 + i));
        chk("R4 dropped word absent", 32'(out_not_empty), 0);
        chk("R4 overflow sticky", 32'(out_ovf), 1);
        clear_flags(3'b100);
        chk("R10 overflow cleared", 32'(out_ovf), 0);
    endtask

    task automatic t_outcount();
        load_out(5, 1'b0);
        write_word(32'h0202_0201);
        write_word(32'h0204_0203);
        write_word(32'h0206_0205);
        for (int i = 1; i <= 4; i++) pop_entry("R7 data", 16'(16'h0200 + i));
        chk("R8 fifo mode no block svc", 32'(out_svc), 0);
        chk("R7 not done early", 32'(out_done), 0);
        pop_entry("R7 data", 16'h0205);
        chk("R7 done at zero", 32'(out_done), 1);
        chk("R7 svc at zero", 32'(out_svc), 1);
        pop_entry("R7 data", 16'h0206);
        chk("R7 done holds", 32'(out_done), 1);
        clear_flags(3'b001);
        chk("R10 out_svc cleared", 32'(out_svc), 0);
    endtask

    task automatic t_outblock();
        load_out(6, 1'b1);
        write_word(32'h0302_0301);
        write_word(32'h0304_0303);
        write_word(32'h0306_0305);
        for (int i = 1; i <= 4; i++) pop_entry("R8 data", 16'(16'h0300 + i));
        chk("R8 block svc", 32'(out_svc), 1);
        chk("R8 not done", 32'(out_done), 0);
        clear_flags(3'b001);
        chk("R10 cleared", 32'(out_svc), 0);
        pop_entry("R8 data", 16'h0305);
        pop_entry("R8 data", 16'h0306);
        chk("R8 done", 32'(out_done), 1);
        chk("R8 end svc", 32'(out_svc), 1);
        clear_flags(3'b001);
    endtask

    task automatic t_inpack();
        load_in(3, 1'b0);
        send_byte(8'h11);
        chk("R5 half word not queued", 32'(in_not_empty), 0);
        send_byte(8'h22);
        read_word("R5 packing", 32'h0022_0011);
        chk("R9 not done", 32'(in_done), 0);
        send_byte(8'h33);
        chk("R9 done", 32'(in_done), 1);
        chk("R9 svc", 32'(in_svc), 1);
        read_word("R6 final odd byte", 32'h0000_0033);
        clear_flags(3'b010);
        chk("R10 in_svc cleared", 32'(in_svc), 0);
    endtask

    task automatic t_inblock();
        load_in(8, 1'b1);
        for (int i = 1; i <= 4; i++) send_byte(8'(i));
        chk("R9 block svc", 32'(in_svc), 1);
        chk("R9 block not done", 32'(in_done), 0);
        clear_flags(3'b010);
        for (int i = 5; i <= 8; i++) send_byte(8'(i));
        chk("R9 done", 32'(in_done), 1);
        chk("R11 full stalls", 32'(rx_ready), 0);
        send_byte(8'h99);
        read_word("R11 w0", 32'h0002_0001);
        read_word("R11 w1", 32'h0004_0003);
        read_word("R11 w2", 32'h0006_0005);
        read_word("R11 w3", 32'h0008_0007);
        chk("R11 stalled byte not taken", 32'(in_not_empty), 0);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        chk("R11 empty read ignored", 32'(in_not_empty), 0);
        chk("R11 ready after empty read", 32'(rx_ready), 1);
        clear_flags(3'b010);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        out_blk_mode = 0; in_blk_mode = 0;
        out_cnt_load = 0; in_cnt_load = 0;
        out_cnt_val = '0; in_cnt_val = '0;
        flag_clr = '0; wr_en = 0; wr_word = '0; rd_en = 0;
        ent_ready = 0; rx_valid = 0; rx_byte = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_split();
        t_odd();
        t_full();
        t_outcount();
        t_outblock();
        t_inpack();
        t_inblock();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule